// File: doc/BRIEF.md
# Integer ALU with NZCV condition flags

This block is the arithmetic and logic stage of a small 32-bit datapath. Each cycle it takes two operands, a 4-bit operation code, the current N, Z, C and V flags, a carry bit from an upstream shifter and a set-flags enable. It produces a result, a write strobe for the destination register and the next value of the four flags.

It offers plain, carry-in and reverse forms of add and subtract, bitwise AND, OR, XOR and bit clear, a move, and four compare or test operations that only update the flags. Every output is registered, so results appear one clock after the inputs are presented. Multi-word arithmetic is built by feeding the returned C flag back into the next operation's flag input.

Top module: `alu_nzcv`

## Requirements
- R1: Result, write strobe and flags are registered: they reflect inputs sampled at the previous rising clock edge, and an active-low reset clears all three to zero.
- R2: Code 4 gives a+b, code 5 gives a+b+C, code 2 gives a-b and code 6 gives a-b+C-1, with C taken from the incoming flags. All four assert the write strobe.
- R3: Code 3 gives b-a and code 7 gives b-a+C-1. Both assert the write strobe.
- R4: Code 0 gives a AND b, code 12 gives a OR b, code 1 gives a XOR b, code 14 gives a AND NOT b (0x11111111 with 0x01100101 gives 0x10011010) and code 13 gives b. All assert the write strobe.
- R5: Code 10 (compare a-b), code 11 (a+b), code 8 (a AND b) and code 9 (a XOR b) set flags from their computed value, which also appears on the result port, but never assert the write strobe.
- R6: With set-flags low, the flag output equals the flag input for every operation.
- R7: For arithmetic operations C is the carry out of bit 31. For subtract forms this is the inverted borrow: 1 when no borrow occurs.
- R8: For arithmetic operations V is set on signed two's-complement overflow of the full operation.
- R9: Flags are packed as N bit 3, Z bit 2, C bit 1, V bit 0. With set-flags high and any code other than 15, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R10: Logic, move and test operations with set-flags high take C from the shifter-carry input and keep V from the flag input. A flag-setting move of zero gives Z=1 and N=0.
- R11: Code 15 is a no-op: result zero, no write, and flags equal the flag input.
- R12: A flag-setting add of the low words, followed by add-with-carry of the high words using the returned C, yields the correct 64-bit sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| shc_i | input | 1 | Carry from the operand shifter, used by logic operations |
| setf_i | input | 1 | Set-flags enable |
| res_o | output | 32 | Registered result |
| wr_o | output | 1 | Registered destination write strobe |
| flags_o | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
Every output of this block is due exactly one rising edge after its inputs are applied: result, write strobe and flags all come from the same register stage, with nothing buffered and nothing held over between operations. The bench changes inputs on a falling edge and reads the outputs on the following falling edge, so exactly one register update lies between stimulus and sample. A separate check reads the outputs just before that edge to confirm they have not yet moved. The carry chain test takes the C flag read at one sample and feeds it into the flag input for the next operation.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_XOR  = 4'd1,
    OP_SUB  = 4'd2,
    OP_RSB  = 4'd3,
    OP_ADD  = 4'd4,
    OP_ADC  = 4'd5,
    OP_SBC  = 4'd6,
    OP_RSC  = 4'd7,
    OP_TST  = 4'd8,
    OP_TEQ  = 4'd9,
    OP_CMP  = 4'd10,
    OP_CMN  = 4'd11,
    OP_OR   = 4'd12,
    OP_MOV  = 4'd13,
    OP_BIC  = 4'd14,
    OP_NONE = 4'd15
  } alu_op_e;

  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;
  localparam int FL_W = 4;

  function automatic logic is_arith(alu_op_e op);
    return op inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_RSB, OP_RSC, OP_CMP, OP_CMN};
  endfunction

  function automatic logic is_cmp(alu_op_e op);
    return op inside {OP_TST, OP_TEQ, OP_CMP, OP_CMN};
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   sum,
  output logic           cout,
  output logic           ovf
);

  localparam int PW = 2 * W + 1;

  // Map every arithmetic form onto x + y + k.
  function automatic logic [PW-1:0] pick_operands(alu_op_e o, logic [W-1:0] p,
                                                  logic [W-1:0] q, logic c);
    logic [W-1:0] x;
    logic [W-1:0] y;
    logic         k;
    case (o)
      OP_ADD, OP_CMN: begin x = p; y = q;  k = 1'b0; end
      OP_ADC:         begin x = p; y = q;  k = c;    end
      OP_SUB, OP_CMP: begin x = p; y = ~q; k = 1'b1; end
      OP_SBC:         begin x = p; y = ~q; k = c;    end
      OP_RSB:         begin x = q; y = ~p; k = 1'b1; end
      OP_RSC:         begin x = q; y = ~p; k = c;    end
      default:        begin x = p; y = q;  k = 1'b0; end
    endcase
    return {x, y, k};
  endfunction

  function automatic logic [W:0] add_ext(logic [W-1:0] x, logic [W-1:0] y, logic k);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, k};
  endfunction

  logic [W-1:0] opx;
  logic [W-1:0] opy;
  logic         opk;
  logic [W:0]   wide;

  always_comb begin
    {opx, opy, opk} = pick_operands(op, a, b, cin);
    wide = add_ext(opx, opy, opk);
    sum  = wide[W-1:0];
    cout = wide[W];
    ovf  = (opx[W-1] == opy[W-1]) && (wide[W-1] != opx[W-1]);
  end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);

  always_comb begin
    case (op)
      OP_AND, OP_TST: res = a & b;
      OP_XOR, OP_TEQ: res = a ^ b;
      OP_OR:          res = a | b;
      OP_BIC:         res = a & ~b;
      OP_MOV:         res = b;
      default:        res = '0;
    endcase
  end

endmodule

// File: rtl/alu_flags.sv
module alu_flags
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     res,
  input  logic             arith_c,
  input  logic             arith_v,
  input  logic             shc,
  input  logic             setf,
  input  logic [FL_W-1:0]  fin,
  output logic [FL_W-1:0]  fout
);

  logic update;
  assign update = setf && (op != OP_NONE);

  always_comb begin
    fout = fin;
    if (update) begin
      fout[FL_N] = res[W-1];
      fout[FL_Z] = (res == '0);
      fout[FL_C] = is_arith(op) ? arith_c : shc;
      fout[FL_V] = is_arith(op) ? arith_v : fin[FL_V];
    end
  end

endmodule

// File: rtl/alu_nzcv.sv
module alu_nzcv
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [FL_W-1:0]   flags_i,
  input  logic              shc_i,
  input  logic              setf_i,
  output logic [W-1:0]      res_o,
  output logic              wr_o,
  output logic [FL_W-1:0]   flags_o
);

  alu_op_e         op;
  logic [W-1:0]    arith_sum;
  logic            arith_c;
  logic            arith_v;
  logic [W-1:0]    logic_res;
  logic [W-1:0]    sel_res;
  logic            nxt_wr;
  logic [FL_W-1:0] nxt_flags;

  assign op = alu_op_e'(op_i);

  alu_arith #(.W(W)) u_arith (
    .op   (op),
    .a    (a_i),
    .b    (b_i),
    .cin  (flags_i[FL_C]),
    .sum  (arith_sum),
    .cout (arith_c),
    .ovf  (arith_v)
  );

  alu_logic #(.W(W)) u_logic (
    .op  (op),
    .a   (a_i),
    .b   (b_i),
    .res (logic_res)
  );

  always_comb begin
    if (op == OP_NONE)  sel_res = '0;
    else if (is_arith(op)) sel_res = arith_sum;
    else                sel_res = logic_res;
    nxt_wr = !is_cmp(op) && (op != OP_NONE);
  end

  alu_flags #(.W(W)) u_flags (
    .op      (op),
    .res     (sel_res),
    .arith_c (arith_c),
    .arith_v (arith_v),
    .shc     (shc_i),
    .setf    (setf_i),
    .fin     (flags_i),
    .fout    (nxt_flags)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_o   <= '0;
      wr_o    <= 1'b0;
      flags_o <= '0;
    end else begin
      res_o   <= sel_res;
      wr_o    <= nxt_wr;
      flags_o <= nxt_flags;
    end
  end

endmodule

// File: rtl/alu_nzcv_chk.sv
module alu_nzcv_chk
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_i,
  input logic [W-1:0]      a_i,
  input logic [W-1:0]      b_i,
  input logic [FL_W-1:0]   flags_i,
  input logic              shc_i,
  input logic              setf_i,
  input logic [W-1:0]      res_o,
  input logic              wr_o,
  input logic [FL_W-1:0]   flags_o
);

  logic            armed;
  alu_op_e         p_op;
  logic [W-1:0]    p_a;
  logic [W-1:0]    p_b;
  logic [FL_W-1:0] p_fl;
  logic            p_shc;
  logic            p_setf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      p_op   <= OP_NONE;
      p_a    <= '0;
      p_b    <= '0;
      p_fl   <= '0;
      p_shc  <= 1'b0;
      p_setf <= 1'b0;
    end else begin
      armed  <= 1'b1;
      p_op   <= alu_op_e'(op_i);
      p_a    <= a_i;
      p_b    <= b_i;
      p_fl   <= flags_i;
      p_shc  <= shc_i;
      p_setf <= setf_i;
    end
  end

  // R5
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && is_cmp(p_op)) |-> !wr_o);

  // R6
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !p_setf) |-> (flags_o == p_fl));

  // R9
  nz_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && p_setf && p_op != OP_NONE) |->
      (flags_o[FL_N] == res_o[W-1]) && (flags_o[FL_Z] == (res_o == '0)));

  // R10
  logic_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && p_setf && !is_arith(p_op) && p_op != OP_NONE) |->
      (flags_o[FL_C] == p_shc) && (flags_o[FL_V] == p_fl[FL_V]));

  // R11
  noop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && p_op == OP_NONE) |-> (!wr_o && res_o == '0 && flags_o == p_fl));

  // R4
  bitclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && p_op == OP_BIC) |-> (res_o == (p_a & ~p_b)));

endmodule

bind alu_nzcv alu_nzcv_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .op_i    (op_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .flags_i (flags_i),
  .shc_i   (shc_i),
  .setf_i  (setf_i),
  .res_o   (res_o),
  .wr_o    (wr_o),
  .flags_o (flags_o)
);

// File: tb/alu_nzcv_bench.sv
`timescale 1ns/1ps
module alu_nzcv_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_i = 4'd0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic [3:0]  flags_i = '0;
  logic        shc_i = 1'b0;
  logic        setf_i = 1'b0;
  logic [31:0] res_o;
  logic        wr_o;
  logic [3:0]  flags_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  alu_nzcv u_alu_nzcv (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .flags_i(flags_i), .shc_i(shc_i), .setf_i(setf_i),
    .res_o(res_o), .wr_o(wr_o), .flags_o(flags_o)
  );

  typedef struct packed {
    logic [3:0]  op;
    logic [31:0] a;
    logic [31:0] b;
    logic [3:0]  fin;
    logic        shc;
    logic        setf;
    logic [31:0] res;
    logic        wr;
    logic [3:0]  fl;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{4'd4,  32'h7FFFFFFF, 32'h00000001, 4'b0000, 1'b0, 1'b1, 32'h80000000, 1'b1, 4'b1001, 4'd8},  // R8 add overflow
    '{4'd4,  32'hFFFFFFFF, 32'h00000001, 4'b0000, 1'b0, 1'b1, 32'h00000000, 1'b1, 4'b0110, 4'd7},  // R7 add carry out
    '{4'd5,  32'h00000005, 32'h00000006, 4'b0010, 1'b0, 1'b1, 32'h0000000C, 1'b1, 4'b0000, 4'd2},  // R2 adc
    '{4'd2,  32'h00000005, 32'h00000005, 4'b0000, 1'b0, 1'b1, 32'h00000000, 1'b1, 4'b0110, 4'd7},  // R7 sub no borrow
    '{4'd2,  32'h00000003, 32'h00000005, 4'b0000, 1'b0, 1'b1, 32'hFFFFFFFE, 1'b1, 4'b1000, 4'd7},  // R7 sub borrow
    '{4'd2,  32'h80000000, 32'h00000001, 4'b0000, 1'b0, 1'b1, 32'h7FFFFFFF, 1'b1, 4'b0011, 4'd8},  // R8 sub overflow
    '{4'd6,  32'h0000000A, 32'h00000003, 4'b0000, 1'b0, 1'b1, 32'h00000006, 1'b1, 4'b0010, 4'd2},  // R2 sbc C=0
    '{4'd3,  32'h00000003, 32'h0000000A, 4'b0000, 1'b0, 1'b1, 32'h00000007, 1'b1, 4'b0010, 4'd3},  // R3 rsb
    '{4'd7,  32'h00000003, 32'h0000000A, 4'b0000, 1'b0, 1'b1, 32'h00000006, 1'b1, 4'b0010, 4'd3},  // R3 rsc C=0
    '{4'd3,  32'h00000001, 32'h80000000, 4'b0000, 1'b0, 1'b1, 32'h7FFFFFFF, 1'b1, 4'b0011, 4'd8},  // R8 rsb overflow
    '{4'd14, 32'h11111111, 32'h01100101, 4'b0001, 1'b0, 1'b1, 32'h10011010, 1'b1, 4'b0001, 4'd4},  // R4 bit clear
    '{4'd0,  32'hF0F0F0F0, 32'h0FF00FF0, 4'b0000, 1'b1, 1'b1, 32'h00F000F0, 1'b1, 4'b0010, 4'd10}, // R10 and, C from shifter
    '{4'd12, 32'h80000000, 32'h00000001, 4'b0000, 1'b0, 1'b1, 32'h80000001, 1'b1, 4'b1000, 4'd4},  // R4 or
    '{4'd1,  32'hAAAA5555, 32'hAAAA5555, 4'b0000, 1'b1, 1'b1, 32'h00000000, 1'b1, 4'b0110, 4'd4},  // R4 xor
    '{4'd13, 32'hDEADBEEF, 32'h00000000, 4'b1011, 1'b1, 1'b1, 32'h00000000, 1'b1, 4'b0111, 4'd10}, // R10 move zero
    '{4'd10, 32'h00000007, 32'h00000007, 4'b0000, 1'b0, 1'b1, 32'h00000000, 1'b0, 4'b0110, 4'd5},  // R5 compare
    '{4'd11, 32'hFFFFFFFF, 32'h00000001, 4'b0000, 1'b0, 1'b1, 32'h00000000, 1'b0, 4'b0110, 4'd5},  // R5 compare negated
    '{4'd8,  32'h0000000F, 32'h000000F0, 4'b0000, 1'b0, 1'b1, 32'h00000000, 1'b0, 4'b0100, 4'd5},  // R5 test
    '{4'd9,  32'h80000000, 32'h00000000, 4'b0000, 1'b0, 1'b1, 32'h80000000, 1'b0, 4'b1000, 4'd5},  // R5 test equal
    '{4'd4,  32'h00000001, 32'h00000002, 4'b1010, 1'b0, 1'b0, 32'h00000003, 1'b1, 4'b1010, 4'd6},  // R6 no flag update
    '{4'd15, 32'h00000001, 32'h00000002, 4'b0101, 1'b0, 1'b1, 32'h00000000, 1'b0, 4'b0101, 4'd11}  // R11 no-op
  };

  // Reference model from the requirements, using wide signed arithmetic.
  function automatic logic [36:0] ref_model(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                                            logic [3:0] fin, logic shc, logic setf);
    longint ua, ub, sa, sb, ci, ut, st;
    logic [31:0] r;
    logic w, n, z, c, v, ar, sub;
    ua = longint'(a); ub = longint'(b);
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ci = fin[1] ? 64'sd1 : 64'sd0;
    ar = 1'b1; sub = 1'b0; ut = 0; st = 0; r = '0;
    case (op)
      4'd4, 4'd11: begin ut = ua + ub;          st = sa + sb;          end
      4'd5:        begin ut = ua + ub + ci;     st = sa + sb + ci;     end
      4'd2, 4'd10: begin ut = ua - ub;          st = sa - sb;          sub = 1'b1; end
      4'd6:        begin ut = ua - ub + ci - 1; st = sa - sb + ci - 1; sub = 1'b1; end
      4'd3:        begin ut = ub - ua;          st = sb - sa;          sub = 1'b1; end
      4'd7:        begin ut = ub - ua + ci - 1; st = sb - sa + ci - 1; sub = 1'b1; end
      default:     ar = 1'b0;
    endcase
    if (ar) r = ut[31:0];
    else case (op)
      4'd0, 4'd8: r = a & b;
      4'd1, 4'd9: r = a ^ b;
      4'd12:      r = a | b;
      4'd13:      r = b;
      4'd14:      r = a & ~b;
      default:    r = '0;
    endcase
    w = !(op inside {4'd8, 4'd9, 4'd10, 4'd11, 4'd15});
    if (!setf || op == 4'd15) begin
      {n, z, c, v} = fin;
    end else begin
      n = r[31];
      z = (r == 32'd0);
      if (ar) begin
        c = sub ? (ut >= 0) : (ut >= 64'sd4294967296);
        v = (st > 64'sd2147483647) || (st < -64'sd2147483648);
      end else begin
        c = shc;
        v = fin[0];
      end
    end
    return {r, w, n, z, c, v};
  endfunction

  task automatic check(string tag, logic [31:0] er, logic ew, logic [3:0] ef);
    n_chk++;
    if (res_o !== er || wr_o !== ew || flags_o !== ef) begin
      n_fail++;
      $display("FAIL %s: got res=%h wr=%b fl=%b, expected res=%h wr=%b fl=%b",
               tag, res_o, wr_o, flags_o, er, ew, ef);
    end
  endtask

  task automatic drive(logic [3:0] op, logic [31:0] a, logic [31:0] b,
                       logic [3:0] fin, logic shc, logic setf);
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; flags_i = fin; shc_i = shc; setf_i = setf;
    @(negedge clk);
  endtask

  logic [31:0] rng = 32'h1234_5678;
  function automatic logic [31:0] next_rng(logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [36:0] e;
    logic [3:0]  cflags;
    // R1: reset holds outputs at zero despite active inputs
    op_i = 4'd4; a_i = 32'h5; b_i = 32'h6; setf_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 1'b0, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 first result", 32'hB, 1'b1, 4'b0000);

    // R1: outputs do not move before the next rising edge
    op_i = 4'd13; b_i = 32'hCAFE0000; setf_i = 1'b0;
    #1;
    check("R1 latency hold", 32'hB, 1'b1, 4'b0000);
    @(negedge clk);
    check("R1 latency due", 32'hCAFE0000, 1'b1, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i].op, VT[i].a, VT[i].b, VT[i].fin, VT[i].shc, VT[i].setf);
      check($sformatf("R%0d vector %0d", VT[i].rq, i), VT[i].res, VT[i].wr, VT[i].fl);
    end

    // R12: 64-bit chain 0x00000001_F0000000 + 0x00000000_10000000
    drive(4'd4, 32'hF0000000, 32'h10000000, 4'b0000, 1'b0, 1'b1);
    check("R12 low word", 32'h00000000, 1'b1, 4'b0110);
    cflags = flags_o;
    drive(4'd5, 32'h00000001, 32'h00000000, cflags, 1'b0, 1'b1);
    check("R12 high word", 32'h00000002, 1'b1, 4'b0000);

    // R2 R3 R7 R8 R9 R10: pseudo-random sweep against the reference model
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  op;
      logic [31:0] a, b;
      logic [3:0]  fin;
      logic        shc, setf;
      rng = next_rng(rng); op = rng[3:0]; fin = rng[7:4]; shc = rng[8]; setf = rng[9] | rng[10];
      rng = next_rng(rng); a = rng;
      rng = next_rng(rng); b = (i % 8 == 0) ? a : rng;
      e = ref_model(op, a, b, fin, shc, setf);
      drive(op, a, b, fin, shc, setf);
      check($sformatf("R9 sweep op %0d", op), e[36:5], e[4], e[3:0]);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule